// File: doc/BRIEF.md
# Dual-Clock FIFO with Mailbox Bypass

This block buffers 36-bit words from a writing port to a reading port, each port running on its own free-running clock. The two clocks may be unrelated or may be one and the same. The queue holds 64 words. Queue pointers cross between the clock domains as Gray code through two-stage synchronizers. The write side sees full and almost-full flags on its own clock, and the read side sees empty and almost-empty flags on its own clock.

Beside the queue there are two single-word mailbox registers. One carries a word from port A to port B and the other carries a word from port B to port A. Each mailbox has a "free" flag on the clock of the port that writes it. A new mail can only be deposited once the previous one has been collected.

The distance from the boundary at which the almost flags trip is chosen from four presets. A two-bit select input picks the preset, and the select is sampled while reset is active.

Top module: `dualClkMailFifo`

## Requirements
- R1: A port-A access with csAN=0, enA=1, wrA=1, mbA=0 while fullA=0 stores dinA in the queue. A port-B access with csBN=0, enB=1, wrB=0, mbB=0 while emptyB=0 loads the oldest stored word onto doutB at that clkB edge. Words leave in the order they were written.
- R2: fullA is 1 exactly when 64 words are held as seen by port A. A queue write attempted while fullA=1 stores nothing, and the held sequence is unchanged.
- R3: emptyB is 1 when port B sees no stored word. A queue read attempted while emptyB=1 leaves doutB and the read position unchanged.
- R4: almostFullA=1 when the free slots seen by port A are no more than the offset. almostEmptyB=1 when the words seen by port B are no more than the offset. The offset is set by offSel during reset: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 4 and 2'b11 gives 4.
- R5: Flags are pessimistic. After a write, emptyB stays 1 until the write pointer has passed two clkB flops. After a read, fullA stays 1 until the read pointer has passed two clkA flops. Both settle within four cycles of the observing clock.
- R6: A port-A access with mbA=1, wrA=1 while mail1FreeA=1 loads dinA into mailbox 1, and mail1FreeA falls at that clkA edge. A port-B access with mbB=1, wrB=0 loads mailbox 1 onto doutB, and mail1FreeA returns to 1 after synchronization. Mailbox traffic leaves the queue untouched.
- R7: A mailbox write while that mailbox's free flag is 0 is ignored, and the pending mail is delivered unchanged.
- R8: Mailbox 2 mirrors mailbox 1. Port B writes it with mbB=1, wrB=1 while mail2FreeB=1. Port A reads it onto doutA with mbA=1, wrA=0. mail2FreeB is on clkB.
- R9: An access with its chip-select high or its enable low has no effect on the queue or the mailboxes.
- R10: Asynchronous reset (rstN=0) clears both pointers and both data outputs, sets emptyB and almostEmptyB, clears fullA and almostFullA, and sets both mailbox free flags.
- R11: With clkA and clkB the same clock, a write and a read on the same edge both take effect, and order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset |
| offSel | input | 2 | Almost-flag offset preset, sampled during reset |
| csAN | input | 1 | Port A select, active low |
| wrA | input | 1 | Port A direction: 1 write, 0 read |
| enA | input | 1 | Port A enable |
| mbA | input | 1 | Port A mailbox select |
| dinA | input | 36 | Port A write data |
| doutA | output | 36 | Port A read data (mailbox 2) |
| csBN | input | 1 | Port B select, active low |
| wrB | input | 1 | Port B direction: 1 write, 0 read |
| enB | input | 1 | Port B enable |
| mbB | input | 1 | Port B mailbox select |
| dinB | input | 36 | Port B write data (mailbox 2) |
| doutB | output | 36 | Port B read data |
| fullA | output | 1 | Queue full, clkA domain |
| almostFullA | output | 1 | Queue almost full, clkA domain |
| mail1FreeA | output | 1 | Mailbox 1 empty, clkA domain |
| emptyB | output | 1 | Queue empty, clkB domain |
| almostEmptyB | output | 1 | Queue almost empty, clkB domain |
| mail2FreeB | output | 1 | Mailbox 2 empty, clkB domain |

## Verification
The assertions check on every cycle that the pointers hold still when an overflow or underflow is attempted, that the stored count never exceeds 64, and that each local Gray pointer changes at most one bit per edge. They also check that full implies almost-full, that empty implies almost-empty, and that a locked mailbox ignores writes. The preset offsets, data order, late flag release across the clock crossing, mailbox round trips and same-clock concurrent traffic can only be shown by the bench. It sweeps every fill level for every preset and compares against counts computed arithmetically.

// File: rtl/dcfPkg.sv
`timescale 1ns/1ps
package dcfPkg;
  // strobes from the port-A control to the datapath
  typedef struct packed {
    logic qWr;
    logic mbxWr;
    logic mbxRd;
  } aStb_t;
  // strobes from the port-B control to the datapath
  typedef struct packed {
    logic qRd;
    logic mbxWr;
    logic mbxRd;
  } bStb_t;
endpackage

// File: rtl/dcfCtrl.sv
`timescale 1ns/1ps
module dcfCtrl import dcfPkg::*; #(
  parameter int ADDR_W   = 6,
  parameter int OFF_SEL0 = 8,
  parameter int OFF_SEL1 = 16,
  parameter int OFF_SEL2 = 4,
  parameter int OFF_SEL3 = 4
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic [1:0]        offSel,
  input  logic              csAN,
  input  logic              wrA,
  input  logic              enA,
  input  logic              mbA,
  input  logic              csBN,
  input  logic              wrB,
  input  logic              enB,
  input  logic              mbB,
  output aStb_t             aStb,
  output bStb_t             bStb,
  output logic [ADDR_W-1:0] wAddr,
  output logic [ADDR_W-1:0] rAddr,
  output logic              full,
  output logic              almostFull,
  output logic              mail1Free,
  output logic              empty,
  output logic              almostEmpty,
  output logic              mail2Free
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PTR_W-1:0] pickOff(input logic [1:0] s);
    case (s)
      2'b00:   return PTR_W'(OFF_SEL0);
      2'b01:   return PTR_W'(OFF_SEL1);
      2'b10:   return PTR_W'(OFF_SEL2);
      default: return PTR_W'(OFF_SEL3);
    endcase
  endfunction

  // ---------------- port A domain ----------------
  logic [PTR_W-1:0] wBin, wGray, rGraySA1, rGraySA2, offA, usedA;
  logic wrTog1, rdTog1SA1, rdTog1SA2, rdTog2, wrTog2SA1, wrTog2SA2, rstActA;
  logic accA, mail2Present;

  assign usedA      = wBin - fromGray(rGraySA2);
  assign full       = (usedA == DEPTH_P);
  assign almostFull = ((DEPTH_P - usedA) <= offA);
  assign mail1Free  = (wrTog1 == rdTog1SA2);
  assign mail2Present = (wrTog2SA2 != rdTog2);
  assign accA       = !csAN && enA;
  assign wAddr      = wBin[ADDR_W-1:0];

  always_comb begin
    aStb.qWr   = accA && wrA && !mbA && !full;
    aStb.mbxWr = accA && wrA && mbA && mail1Free;
    aStb.mbxRd = accA && !wrA && mbA;
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      wBin <= '0; wGray <= '0; rGraySA1 <= '0; rGraySA2 <= '0;
      wrTog1 <= 1'b0; rdTog1SA1 <= 1'b0; rdTog1SA2 <= 1'b0;
      rdTog2 <= 1'b0; wrTog2SA1 <= 1'b0; wrTog2SA2 <= 1'b0;
      rstActA <= 1'b1;
    end else begin
      rstActA   <= 1'b0;
      rGraySA1  <= rGray;
      rGraySA2  <= rGraySA1;
      rdTog1SA1 <= rdTog1;
      rdTog1SA2 <= rdTog1SA1;
      wrTog2SA1 <= wrTog2;
      wrTog2SA2 <= wrTog2SA1;
      if (aStb.qWr) begin
        wBin  <= wBin + 1'b1;
        wGray <= toGray(wBin + 1'b1);
      end
      if (aStb.mbxWr) wrTog1 <= ~wrTog1;
      if (aStb.mbxRd && mail2Present) rdTog2 <= ~rdTog2;
    end
  end

  // preset offset: sampled during reset and on the first edge after it
  always_ff @(posedge clkA) begin
    if (rstActA) offA <= pickOff(offSel);
  end

  // ---------------- port B domain ----------------
  logic [PTR_W-1:0] rBin, rGray, wGraySB1, wGraySB2, offB, usedB;
  logic rdTog1, wrTog1SB1, wrTog1SB2, wrTog2, rdTog2SB1, rdTog2SB2, rstActB;
  logic accB, mail1Present;

  assign usedB        = fromGray(wGraySB2) - rBin;
  assign empty        = (usedB == '0);
  assign almostEmpty  = (usedB <= offB);
  assign mail2Free    = (wrTog2 == rdTog2SB2);
  assign mail1Present = (wrTog1SB2 != rdTog1);
  assign accB         = !csBN && enB;
  assign rAddr        = rBin[ADDR_W-1:0];

  always_comb begin
    bStb.qRd   = accB && !wrB && !mbB && !empty;
    bStb.mbxWr = accB && wrB && mbB && mail2Free;
    bStb.mbxRd = accB && !wrB && mbB;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      rBin <= '0; rGray <= '0; wGraySB1 <= '0; wGraySB2 <= '0;
      rdTog1 <= 1'b0; wrTog1SB1 <= 1'b0; wrTog1SB2 <= 1'b0;
      wrTog2 <= 1'b0; rdTog2SB1 <= 1'b0; rdTog2SB2 <= 1'b0;
      rstActB <= 1'b1;
    end else begin
      rstActB   <= 1'b0;
      wGraySB1  <= wGray;
      wGraySB2  <= wGraySB1;
      wrTog1SB1 <= wrTog1;
      wrTog1SB2 <= wrTog1SB1;
      rdTog2SB1 <= rdTog2;
      rdTog2SB2 <= rdTog2SB1;
      if (bStb.qRd) begin
        rBin  <= rBin + 1'b1;
        rGray <= toGray(rBin + 1'b1);
      end
      if (bStb.mbxRd && mail1Present) rdTog1 <= ~rdTog1;
      if (bStb.mbxWr) wrTog2 <= ~wrTog2;
    end
  end

  always_ff @(posedge clkB) begin
    if (rstActB) offB <= pickOff(offSel);
  end

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge clkA) disable iff (!rstN)
    (full && !csAN && enA && wrA && !mbA) |=> $stable(wBin)); // R2
  AST_USED_BOUND: assert property (@(posedge clkA) disable iff (!rstN)
    usedA <= DEPTH_P); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clkB) disable iff (!rstN)
    (empty && !csBN && enB && !wrB && !mbB) |=> $stable(rBin)); // R3
  AST_WGRAY_STEP: assert property (@(posedge clkA) disable iff (!rstN)
    $onehot0(wGray ^ $past(wGray))); // R5
  AST_RGRAY_STEP: assert property (@(posedge clkB) disable iff (!rstN)
    $onehot0(rGray ^ $past(rGray))); // R5
  AST_FULL_NESTS_AF: assert property (@(posedge clkA) disable iff (!rstN || rstActA)
    full |-> almostFull); // R4
  AST_EMPTY_NESTS_AE: assert property (@(posedge clkB) disable iff (!rstN || rstActB)
    empty |-> almostEmpty); // R4
  AST_MBX1_LOCKED: assert property (@(posedge clkA) disable iff (!rstN)
    (!mail1Free && accA && wrA && mbA) |=> $stable(wrTog1)); // R7
  AST_MBX2_LOCKED: assert property (@(posedge clkB) disable iff (!rstN)
    (!mail2Free && accB && wrB && mbB) |=> $stable(wrTog2)); // R7
endmodule

// File: rtl/dcfData.sv
`timescale 1ns/1ps
module dcfData import dcfPkg::*; #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  aStb_t             aStb,
  input  bStb_t             bStb,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] dinA,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutA,
  output logic [DATA_W-1:0] doutB
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mbx1Data, mbx2Data;

  always_ff @(posedge clkA) begin
    if (aStb.qWr) mem[wAddr] <= dinA;
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      mbx1Data <= '0;
      doutA    <= '0;
    end else begin
      if (aStb.mbxWr) mbx1Data <= dinA;
      if (aStb.mbxRd) doutA <= mbx2Data;
    end
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      mbx2Data <= '0;
      doutB    <= '0;
    end else begin
      if (bStb.mbxWr) mbx2Data <= dinB;
      if (bStb.qRd)        doutB <= mem[rAddr];
      else if (bStb.mbxRd) doutB <= mbx1Data;
    end
  end

  // a queue read and a mailbox read are exclusive per edge
  AST_B_READ_EXCL: assert property (@(posedge clkB) disable iff (!rstN)
    !(bStb.qRd && bStb.mbxRd)); // R1
endmodule

// File: rtl/dualClkMailFifo.sv
`timescale 1ns/1ps
module dualClkMailFifo import dcfPkg::*; #(
  parameter int DATA_W   = 36,
  parameter int ADDR_W   = 6,
  parameter int OFF_SEL0 = 8,
  parameter int OFF_SEL1 = 16,
  parameter int OFF_SEL2 = 4,
  parameter int OFF_SEL3 = 4
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic [1:0]        offSel,
  input  logic              csAN,
  input  logic              wrA,
  input  logic              enA,
  input  logic              mbA,
  input  logic [DATA_W-1:0] dinA,
  output logic [DATA_W-1:0] doutA,
  input  logic              csBN,
  input  logic              wrB,
  input  logic              enB,
  input  logic              mbB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutB,
  output logic              fullA,
  output logic              almostFullA,
  output logic              mail1FreeA,
  output logic              emptyB,
  output logic              almostEmptyB,
  output logic              mail2FreeB
);
  aStb_t aStb;
  bStb_t bStb;
  logic [ADDR_W-1:0] wAddr, rAddr;

  dcfCtrl #(
    .ADDR_W(ADDR_W), .OFF_SEL0(OFF_SEL0), .OFF_SEL1(OFF_SEL1),
    .OFF_SEL2(OFF_SEL2), .OFF_SEL3(OFF_SEL3)
  ) u_ctrl (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .offSel(offSel),
    .csAN(csAN), .wrA(wrA), .enA(enA), .mbA(mbA),
    .csBN(csBN), .wrB(wrB), .enB(enB), .mbB(mbB),
    .aStb(aStb), .bStb(bStb), .wAddr(wAddr), .rAddr(rAddr),
    .full(fullA), .almostFull(almostFullA), .mail1Free(mail1FreeA),
    .empty(emptyB), .almostEmpty(almostEmptyB), .mail2Free(mail2FreeB)
  );

  dcfData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .aStb(aStb), .bStb(bStb),
    .wAddr(wAddr), .rAddr(rAddr), .dinA(dinA), .dinB(dinB),
    .doutA(doutA), .doutB(doutB)
  );
endmodule

// File: tb/dualClkMailFifo_tb.sv
`timescale 1ns/1ps
module dualClkMailFifo_tb;
  logic clkA = 1'b0, clkBFree = 1'b0, sameClk = 1'b0;
  logic clkB;
  logic rstN = 1'b0;
  logic [1:0] offSel = 2'b00;
  logic csAN = 1'b1, wrA = 1'b0, enA = 1'b0, mbA = 1'b0;
  logic csBN = 1'b1, wrB = 1'b0, enB = 1'b0, mbB = 1'b0;
  logic [35:0] dinA = '0, dinB = '0;
  logic [35:0] doutA, doutB;
  logic fullA, almostFullA, mail1FreeA, emptyB, almostEmptyB, mail2FreeB;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #10 clkA = ~clkA;     // 50 MHz
  always #13 clkBFree = ~clkBFree;
  assign clkB = sameClk ? clkA : clkBFree;

  dualClkMailFifo u_dut (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .offSel(offSel),
    .csAN(csAN), .wrA(wrA), .enA(enA), .mbA(mbA), .dinA(dinA), .doutA(doutA),
    .csBN(csBN), .wrB(wrB), .enB(enB), .mbB(mbB), .dinB(dinB), .doutB(doutB),
    .fullA(fullA), .almostFullA(almostFullA), .mail1FreeA(mail1FreeA),
    .emptyB(emptyB), .almostEmptyB(almostEmptyB), .mail2FreeB(mail2FreeB)
  );

  function automatic logic [35:0] pat(input int s, input int k);
    return {4'(s), 16'(k * 37 + 5), 16'(~k)};
  endfunction

  function automatic int offOf(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : 4;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idleA(); csAN = 1'b1; enA = 1'b0; wrA = 1'b0; mbA = 1'b0; endtask
  task automatic idleB(); csBN = 1'b1; enB = 1'b0; wrB = 1'b0; mbB = 1'b0; endtask
  task automatic waitA(input int n); repeat (n) @(negedge clkA); endtask
  task automatic waitB(input int n); repeat (n) @(negedge clkB); endtask

  task automatic accessA(input logic cs, input logic en, input logic w,
                         input logic m, input logic [35:0] d);
    @(negedge clkA); csAN = cs; enA = en; wrA = w; mbA = m; dinA = d;
    @(negedge clkA); idleA();
  endtask
  task automatic accessB(input logic cs, input logic en, input logic w,
                         input logic m, input logic [35:0] d);
    @(negedge clkB); csBN = cs; enB = en; wrB = w; mbB = m; dinB = d;
    @(negedge clkB); idleB();
  endtask
  task automatic pushA(input logic [35:0] d); accessA(1'b0, 1'b1, 1'b1, 1'b0, d); endtask
  task automatic popB(); accessB(1'b0, 1'b1, 1'b0, 1'b0, '0); endtask

  task automatic doReset(input int s);
    offSel = 2'(s);
    rstN = 1'b0;
    waitA(3); waitB(3);
    @(negedge clkA); rstN = 1'b1;
    waitA(2); waitB(2);
  endtask

  initial begin
    idleA(); idleB();
    // R1 R2 R3 R4 R10: sweep every fill level for every preset
    for (int s = 0; s < 4; s++) begin
      int off;
      off = offOf(s);
      doReset(s);
      chk("R10", "emptyB", 36'(emptyB), 36'd1);
      chk("R10", "almostEmptyB", 36'(almostEmptyB), 36'd1);
      chk("R10", "fullA", 36'(fullA), 36'd0);
      chk("R10", "almostFullA", 36'(almostFullA), 36'd0);
      chk("R10", "mail1FreeA", 36'(mail1FreeA), 36'd1);
      chk("R10", "mail2FreeB", 36'(mail2FreeB), 36'd1);
      chk("R10", "doutB", doutB, 36'd0);
      chk("R10", "doutA", doutA, 36'd0);
      for (int k = 1; k <= 64; k++) begin
        pushA(pat(s, k - 1));
        chk("R2", "fullA during fill", 36'(fullA), 36'(k == 64));
        chk("R4", "almostFullA during fill", 36'(almostFullA), 36'((64 - k) <= off));
      end
      pushA(36'hF_FFFF_FFFF);   // overflow attempt
      chk("R2", "fullA after overflow", 36'(fullA), 36'd1);
      waitB(4);
      chk("R3", "emptyB when full", 36'(emptyB), 36'd0);
      chk("R4", "almostEmptyB when full", 36'(almostEmptyB), 36'd0);
      for (int k = 1; k <= 64; k++) begin
        popB();
        chk("R1", "doutB order", doutB, pat(s, k - 1));
        chk("R4", "almostEmptyB during drain", 36'(almostEmptyB), 36'((64 - k) <= off));
        chk("R3", "emptyB during drain", 36'(emptyB), 36'(k == 64));
      end
      popB();   // underflow attempt
      chk("R3", "doutB after underflow", doutB, pat(s, 63));
      chk("R3", "emptyB after underflow", 36'(emptyB), 36'd1);
    end

    // R5: late release of empty and full
    doReset(0);
    pushA(pat(7, 0));
    chk("R5", "emptyB right after write", 36'(emptyB), 36'd1);
    waitB(4);
    chk("R5", "emptyB settled", 36'(emptyB), 36'd0);
    for (int k = 1; k < 64; k++) pushA(pat(7, k));
    chk("R5", "fullA at 64", 36'(fullA), 36'd1);
    popB();
    chk("R5", "fullA right after read", 36'(fullA), 36'd1);
    waitA(4);
    chk("R5", "fullA settled", 36'(fullA), 36'd0);

    // R9: unqualified accesses ignored
    doReset(0);
    accessA(1'b1, 1'b1, 1'b1, 1'b0, 36'h1);
    accessA(1'b0, 1'b0, 1'b1, 1'b0, 36'h2);
    accessA(1'b1, 1'b1, 1'b1, 1'b1, 36'h3);
    accessB(1'b1, 1'b1, 1'b1, 1'b1, 36'h4);
    waitA(5); waitB(5);
    chk("R9", "emptyB after deselected writes", 36'(emptyB), 36'd1);
    chk("R9", "mail1FreeA after deselected write", 36'(mail1FreeA), 36'd1);
    chk("R9", "mail2FreeB after deselected write", 36'(mail2FreeB), 36'd1);

    // R6 R7: mailbox 1
    accessA(1'b0, 1'b1, 1'b1, 1'b1, 36'hA_1111_0001);
    chk("R6", "mail1FreeA after write", 36'(mail1FreeA), 36'd0);
    accessA(1'b0, 1'b1, 1'b1, 1'b1, 36'hB_2222_0002);   // locked
    waitB(4);
    accessB(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chk("R7", "doutB mail1 kept first word", doutB, 36'hA_1111_0001);
    chk("R6", "queue untouched by mail", 36'(emptyB), 36'd1);
    waitA(5);
    chk("R6", "mail1FreeA after read", 36'(mail1FreeA), 36'd1);
    accessA(1'b0, 1'b1, 1'b1, 1'b1, 36'hC_3333_0003);
    waitB(4);
    accessB(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chk("R6", "doutB second mail", doutB, 36'hC_3333_0003);

    // R8 R7: mailbox 2
    accessB(1'b0, 1'b1, 1'b1, 1'b1, 36'hD_4444_0004);
    chk("R8", "mail2FreeB after write", 36'(mail2FreeB), 36'd0);
    accessB(1'b0, 1'b1, 1'b1, 1'b1, 36'hE_5555_0005);   // locked
    waitA(4);
    accessA(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chk("R8", "doutA mail2", doutA, 36'hD_4444_0004);
    waitB(5);
    chk("R8", "mail2FreeB after read", 36'(mail2FreeB), 36'd1);

    // R11: one shared clock, write and read on the same edges
    sameClk = 1'b1;
    doReset(0);
    for (int k = 0; k < 3; k++) pushA(pat(5, k));
    waitA(4);
    for (int i = 0; i < 10; i++) begin
      @(negedge clkA);
      if (i > 0) chk("R11", "doutB concurrent", doutB, pat(5, i - 1));
      csAN = 1'b0; enA = 1'b1; wrA = 1'b1; mbA = 1'b0; dinA = pat(5, i + 3);
      csBN = 1'b0; enB = 1'b1; wrB = 1'b0; mbB = 1'b0;
    end
    @(negedge clkA);
    idleA(); idleB();
    chk("R11", "doutB concurrent last", doutB, pat(5, 9));
    waitA(4);
    for (int k = 10; k < 13; k++) begin
      popB();
      chk("R11", "doutB tail", doutB, pat(5, k));
    end
    chk("R11", "emptyB after tail", 36'(emptyB), 36'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clkA);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule